// File: doc/BRIEF.md
# Dual-Port Mailbox Memory

A 2048-word, 8-bit memory with two independent ports, left and right, each able to read or write any word in every clock cycle. Both ports run on one clock. Each port has an active-low chip enable, a read/write select, an active-low output enable, an address, write data and an active-low write-permit input from an outside contention arbiter. Read data comes back one cycle after the request, together with a valid flag that stands in for a released bus.

The two highest words also act as mailboxes between the ports. The left port posts to the right port by writing the top word. This raises the right port's interrupt, which the right port clears by reading that word. The right port posts to the left port through the word just below the top, and the left port clears that interrupt by reading it. The posted byte is also stored like any other word, so the reader gets the message along with the acknowledgement.

Top module: `mbox_dpram`

## Requirements
- R1: With chip enable low and read/write low (write) and busy_n high, the write data is stored at the address on the clock edge.
- R2: With chip enable low, read/write high and output enable low (read), rvalid is high in the next cycle and rdata carries the stored byte. Any other combination, including a disabled port or output enable high, gives rvalid low and rdata zero in the next cycle.
- R3: A read from one port in the same cycle as a write to the same address from the other port returns the byte held before that write.
- R4: A write made while busy_n is low changes no memory word and raises no interrupt.
- R5: A permitted left write to address 0x7FF (all ones) drives r_int_n low in the next cycle. It stays low until the right port clears it, and a left read of 0x7FF does not clear it.
- R6: A right read of 0x7FF drives r_int_n high in the next cycle. A right access to 0x7FF with output enable high does not clear it.
- R7: A permitted right write to 0x7FE drives l_int_n low in the next cycle, and a left read of 0x7FE drives it high again.
- R8: When a set and a clear of the same interrupt fall in one cycle, the interrupt is active in the next cycle.
- R9: A mailbox word keeps the posted byte, and the reading port receives it on the clearing read.
- R10: A synchronous active-high reset makes both interrupts inactive (high) and both rvalid low in the following cycle. It leaves memory contents unchanged.
- R11: If both ports write the same address in one cycle, the left port's byte is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| l_cen_n | input | 1 | Left chip enable, active low |
| l_rw | input | 1 | Left access type: 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_busy_n | input | 1 | Left write permit, low inhibits writes |
| l_addr | input | 11 | Left word address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data, zero when not valid |
| l_rvalid | output | 1 | Left read data valid |
| l_int_n | output | 1 | Left interrupt, active low |
| r_cen_n | input | 1 | Right chip enable, active low |
| r_rw | input | 1 | Right access type: 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_busy_n | input | 1 | Right write permit, low inhibits writes |
| r_addr | input | 11 | Right word address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data, zero when not valid |
| r_rvalid | output | 1 | Right read data valid |
| r_int_n | output | 1 | Right interrupt, active low |

## Verification
The case that matters is when a mailbox post from one port and the acknowledging read from the other port land on the same mailbox word in the same cycle. In that cycle the flag sees a set and a clear at once, and the memory sees a write and a read at once. The bench provokes this on both mailboxes by driving the opposing write and read on the same edge. It then checks that the interrupt is active in the next cycle and that the reader got the byte held before the new post. A second pairing, both ports writing one ordinary word together, is judged by reading the word back afterwards.

// File: rtl/mbox_dpram_pkg.sv
package mbox_dpram_pkg;

    // Decoded intent of one port in the current cycle
    typedef struct packed {
        logic wr_en;   // permitted write
        logic rd_en;   // read with output enabled
        logic mb_set;  // post to the peer's mailbox
        logic mb_clr;  // acknowledge own mailbox
    } port_req_t;

    // Registered read-valid state of the two ports
    typedef struct packed {
        logic l_rv;
        logic r_rv;
    } rv_state_t;

endpackage

// File: rtl/mbox_dpram_port.sv
module mbox_dpram_port
    import mbox_dpram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter logic [ADDR_W-1:0] POST_ADDR = '1,
    parameter logic [ADDR_W-1:0] ACK_ADDR  = '0
) (
    input  logic              cen_n,
    input  logic              rw,
    input  logic              oe_n,
    input  logic              busy_n,
    input  logic [ADDR_W-1:0] addr,
    output port_req_t         req
);

    always_comb begin
        req.wr_en  = !cen_n && !rw && busy_n;
        req.rd_en  = !cen_n && rw && !oe_n;
        req.mb_set = req.wr_en && (addr == POST_ADDR);
        req.mb_clr = req.rd_en && (addr == ACK_ADDR);
    end

endmodule

// File: rtl/mbox_dpram_mem.sv
module mbox_dpram_mem #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              a_we,
    input  logic              a_re,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_we,
    input  logic              b_re,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] a_rd_q;
    logic [DATA_W-1:0] b_rd_q;

    // Reads see the contents before this edge's writes; port A is applied
    // last so it owns a same-address collision.
    always_ff @(posedge clk) begin
        if (a_re) a_rd_q <= mem_q[a_addr];
        if (b_re) b_rd_q <= mem_q[b_addr];
        if (b_we) mem_q[b_addr] <= b_wdata;
        if (a_we) mem_q[a_addr] <= a_wdata;
    end

    assign a_rdata = a_rd_q;
    assign b_rdata = b_rd_q;

endmodule

// File: rtl/mbox_dpram_flag.sv
module mbox_dpram_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic active
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr) flag_d = 1'b0;
        if (set) flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= flag_d;
    end

    assign active = flag_q;

endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
    import mbox_dpram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_cen_n,
    input  logic              l_rw,
    input  logic              l_oe_n,
    input  logic              l_busy_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rvalid,
    output logic              l_int_n,
    input  logic              r_cen_n,
    input  logic              r_rw,
    input  logic              r_oe_n,
    input  logic              r_busy_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rvalid,
    output logic              r_int_n
);

    localparam logic [ADDR_W-1:0] MB_TO_R = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] MB_TO_L = {{(ADDR_W-1){1'b1}}, 1'b0};

    port_req_t l_req, r_req;
    rv_state_t st_d, st_q;
    logic [DATA_W-1:0] l_rd_raw, r_rd_raw;
    logic l_flag, r_flag;

    mbox_dpram_port #(
        .ADDR_W(ADDR_W), .POST_ADDR(MB_TO_R), .ACK_ADDR(MB_TO_L)
    ) u_lport (
        .cen_n(l_cen_n), .rw(l_rw), .oe_n(l_oe_n), .busy_n(l_busy_n),
        .addr(l_addr), .req(l_req)
    );

    mbox_dpram_port #(
        .ADDR_W(ADDR_W), .POST_ADDR(MB_TO_L), .ACK_ADDR(MB_TO_R)
    ) u_rport (
        .cen_n(r_cen_n), .rw(r_rw), .oe_n(r_oe_n), .busy_n(r_busy_n),
        .addr(r_addr), .req(r_req)
    );

    mbox_dpram_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk),
        .a_we(l_req.wr_en), .a_re(l_req.rd_en), .a_addr(l_addr),
        .a_wdata(l_wdata), .a_rdata(l_rd_raw),
        .b_we(r_req.wr_en), .b_re(r_req.rd_en), .b_addr(r_addr),
        .b_wdata(r_wdata), .b_rdata(r_rd_raw)
    );

    // Interrupt toward the right port: posted by left, acknowledged by right
    mbox_dpram_flag u_flag_r (
        .clk(clk), .rst(rst), .set(l_req.mb_set), .clr(r_req.mb_clr),
        .active(r_flag)
    );

    // Interrupt toward the left port: posted by right, acknowledged by left
    mbox_dpram_flag u_flag_l (
        .clk(clk), .rst(rst), .set(r_req.mb_set), .clr(l_req.mb_clr),
        .active(l_flag)
    );

    always_comb begin
        st_d      = st_q;
        st_d.l_rv = l_req.rd_en;
        st_d.r_rv = r_req.rd_en;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign l_rvalid = st_q.l_rv;
    assign r_rvalid = st_q.r_rv;
    assign l_rdata  = st_q.l_rv ? l_rd_raw : '0;
    assign r_rdata  = st_q.r_rv ? r_rd_raw : '0;
    assign l_int_n  = !l_flag;
    assign r_int_n  = !r_flag;

endmodule

// File: rtl/mbox_dpram_chk.sv
module mbox_dpram_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              l_cen_n,
    input logic              l_rw,
    input logic              l_oe_n,
    input logic              l_busy_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_rvalid,
    input logic              l_int_n,
    input logic              r_cen_n,
    input logic              r_rw,
    input logic              r_oe_n,
    input logic              r_busy_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_rvalid,
    input logic              r_int_n
);

    localparam logic [ADDR_W-1:0] TOP  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] NEXT = {{(ADDR_W-1){1'b1}}, 1'b0};

    logic l_wr, l_rd, r_wr, r_rd;
    assign l_wr = !l_cen_n && !l_rw && l_busy_n;
    assign l_rd = !l_cen_n && l_rw && !l_oe_n;
    assign r_wr = !r_cen_n && !r_rw && r_busy_n;
    assign r_rd = !r_cen_n && r_rw && !r_oe_n;

    assert_rvalid_l_R2: assert property (@(posedge clk) disable iff (rst)
        l_rd |=> l_rvalid);
    assert_rvalid_r_R2: assert property (@(posedge clk) disable iff (rst)
        r_rd |=> r_rvalid);
    assert_noread_l_R2: assert property (@(posedge clk) disable iff (rst)
        !l_rd |=> (!l_rvalid && l_rdata == '0));
    assert_noread_r_R2: assert property (@(posedge clk) disable iff (rst)
        !r_rd |=> (!r_rvalid && r_rdata == '0));

    assert_quiet_r_R4: assert property (@(posedge clk) disable iff (rst)
        (r_int_n && !(l_wr && l_addr == TOP)) |=> r_int_n);
    assert_quiet_l_R4: assert property (@(posedge clk) disable iff (rst)
        (l_int_n && !(r_wr && r_addr == NEXT)) |=> l_int_n);

    assert_post_r_R5: assert property (@(posedge clk) disable iff (rst)
        (l_wr && l_addr == TOP) |=> !r_int_n);
    assert_hold_r_R5: assert property (@(posedge clk) disable iff (rst)
        (!r_int_n && !(r_rd && r_addr == TOP)) |=> !r_int_n);
    assert_ack_r_R6: assert property (@(posedge clk) disable iff (rst)
        (r_rd && r_addr == TOP && !(l_wr && l_addr == TOP)) |=> r_int_n);

    assert_post_l_R7: assert property (@(posedge clk) disable iff (rst)
        (r_wr && r_addr == NEXT) |=> !l_int_n);
    assert_hold_l_R7: assert property (@(posedge clk) disable iff (rst)
        (!l_int_n && !(l_rd && l_addr == NEXT)) |=> !l_int_n);
    assert_ack_l_R7: assert property (@(posedge clk) disable iff (rst)
        (l_rd && l_addr == NEXT && !(r_wr && r_addr == NEXT)) |=> l_int_n);

    assert_setwins_r_R8: assert property (@(posedge clk) disable iff (rst)
        (l_wr && l_addr == TOP && r_rd && r_addr == TOP) |=> !r_int_n);
    assert_setwins_l_R8: assert property (@(posedge clk) disable iff (rst)
        (r_wr && r_addr == NEXT && l_rd && l_addr == NEXT) |=> !l_int_n);

    assert_reset_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (l_int_n && r_int_n && !l_rvalid && !r_rvalid));

endmodule

bind mbox_dpram mbox_dpram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst),
    .l_cen_n(l_cen_n), .l_rw(l_rw), .l_oe_n(l_oe_n), .l_busy_n(l_busy_n),
    .l_addr(l_addr), .l_rdata(l_rdata), .l_rvalid(l_rvalid), .l_int_n(l_int_n),
    .r_cen_n(r_cen_n), .r_rw(r_rw), .r_oe_n(r_oe_n), .r_busy_n(r_busy_n),
    .r_addr(r_addr), .r_rdata(r_rdata), .r_rvalid(r_rvalid), .r_int_n(r_int_n)
);

// File: tb/mbox_dpram_tb.sv
module mbox_dpram_tb;

    localparam int AW = 11;
    localparam int DW = 8;
    localparam int NV = 20;

    // Operation codes used in the vector table
    localparam logic [1:0] OI = 2'd0; // idle (chip disabled)
    localparam logic [1:0] OW = 2'd1; // write
    localparam logic [1:0] OR = 2'd2; // read, output enabled
    localparam logic [1:0] OH = 2'd3; // read with output enable high

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic l_cen_n, l_rw, l_oe_n, l_busy_n, r_cen_n, r_rw, r_oe_n, r_busy_n;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
    logic l_rvalid, r_rvalid, l_int_n, r_int_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mbox_dpram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst),
        .l_cen_n(l_cen_n), .l_rw(l_rw), .l_oe_n(l_oe_n), .l_busy_n(l_busy_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .l_rvalid(l_rvalid), .l_int_n(l_int_n),
        .r_cen_n(r_cen_n), .r_rw(r_rw), .r_oe_n(r_oe_n), .r_busy_n(r_busy_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
        .r_rvalid(r_rvalid), .r_int_n(r_int_n)
    );

    // Vector layout: [63:42] left stimulus, [41:20] right stimulus, [19:0] expected
    function automatic logic [63:0] mk(
        input logic [1:0] lop, input logic [10:0] la, input logic [7:0] ld, input logic lb,
        input logic [1:0] rop, input logic [10:0] ra, input logic [7:0] rd, input logic rb,
        input logic eli, input logic eri,
        input logic elv, input logic [7:0] eld, input logic erv, input logic [7:0] erd);
        return {lop, la, ld, lb, rop, ra, rd, rb, eli, eri, elv, eld, erv, erd};
    endfunction

    localparam logic [63:0] VEC [NV] = '{
        mk(OW,11'h010,8'hA5,1, OI,11'h000,8'h00,1, 1,1, 0,8'h00, 0,8'h00), // 0  R1
        mk(OR,11'h010,8'h00,1, OW,11'h020,8'h3C,1, 1,1, 1,8'hA5, 0,8'h00), // 1  R1
        mk(OW,11'h020,8'h77,1, OR,11'h020,8'h00,1, 1,1, 0,8'h00, 1,8'h3C), // 2  R3
        mk(OR,11'h020,8'h00,1, OI,11'h000,8'h00,1, 1,1, 1,8'h77, 0,8'h00), // 3  R3
        mk(OW,11'h030,8'h11,1, OI,11'h000,8'h00,1, 1,1, 0,8'h00, 0,8'h00), // 4  R1
        mk(OW,11'h030,8'h99,0, OI,11'h000,8'h00,1, 1,1, 0,8'h00, 0,8'h00), // 5  R4
        mk(OI,11'h000,8'h00,1, OR,11'h030,8'h00,1, 1,1, 0,8'h00, 1,8'h11), // 6  R4
        mk(OW,11'h7FF,8'h5A,0, OI,11'h000,8'h00,1, 1,1, 0,8'h00, 0,8'h00), // 7  R4
        mk(OW,11'h7FF,8'h5A,1, OI,11'h000,8'h00,1, 1,0, 0,8'h00, 0,8'h00), // 8  R5
        mk(OR,11'h7FF,8'h00,1, OI,11'h000,8'h00,1, 1,0, 1,8'h5A, 0,8'h00), // 9  R5
        mk(OI,11'h000,8'h00,1, OI,11'h000,8'h00,1, 1,0, 0,8'h00, 0,8'h00), // 10 R5
        mk(OI,11'h000,8'h00,1, OH,11'h7FF,8'h00,1, 1,0, 0,8'h00, 0,8'h00), // 11 R6
        mk(OI,11'h000,8'h00,1, OR,11'h7FF,8'h00,1, 1,1, 0,8'h00, 1,8'h5A), // 12 R6 R9
        mk(OI,11'h000,8'h00,1, OW,11'h7FE,8'hC3,1, 0,1, 0,8'h00, 0,8'h00), // 13 R7
        mk(OR,11'h7FE,8'h00,1, OW,11'h7FE,8'hE1,1, 0,1, 1,8'hC3, 0,8'h00), // 14 R8
        mk(OR,11'h7FE,8'h00,1, OI,11'h000,8'h00,1, 1,1, 1,8'hE1, 0,8'h00), // 15 R7
        mk(OW,11'h040,8'hAA,1, OW,11'h040,8'hBB,1, 1,1, 0,8'h00, 0,8'h00), // 16 R11
        mk(OI,11'h000,8'h00,1, OR,11'h040,8'h00,1, 1,1, 0,8'h00, 1,8'hAA), // 17 R11
        mk(OW,11'h7FF,8'h01,1, OR,11'h7FF,8'h00,1, 1,0, 0,8'h00, 1,8'h5A), // 18 R8
        mk(OI,11'h000,8'h00,1, OI,11'h000,8'h00,1, 1,0, 0,8'h00, 0,8'h00)  // 19 R8
    };

    function automatic string vreq(input int i);
        case (i)
            0, 1, 4:   return "R1";
            2, 3:      return "R3";
            5, 6, 7:   return "R4";
            8, 9, 10:  return "R5";
            11:        return "R6";
            12:        return "R6 R9";
            13, 15:    return "R7";
            14, 18, 19: return "R8";
            default:   return "R11";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive_l(input logic [1:0] op, input logic [10:0] a,
                           input logic [7:0] d, input logic b);
        l_cen_n  = (op == OI);
        l_rw     = (op != OW);
        l_oe_n   = (op != OR);
        l_addr   = a;
        l_wdata  = d;
        l_busy_n = b;
    endtask

    task automatic drive_r(input logic [1:0] op, input logic [10:0] a,
                           input logic [7:0] d, input logic b);
        r_cen_n  = (op == OI);
        r_rw     = (op != OW);
        r_oe_n   = (op != OR);
        r_addr   = a;
        r_wdata  = d;
        r_busy_n = b;
    endtask

    task automatic check_all(input string req, input logic eli, input logic eri,
                             input logic elv, input logic [7:0] eld,
                             input logic erv, input logic [7:0] erd);
        chk(req, "l_int_n",  int'(l_int_n),  int'(eli));
        chk(req, "r_int_n",  int'(r_int_n),  int'(eri));
        chk(req, "l_rvalid", int'(l_rvalid), int'(elv));
        chk(req, "l_rdata",  int'(l_rdata),  int'(eld));
        chk(req, "r_rvalid", int'(r_rvalid), int'(erv));
        chk(req, "r_rdata",  int'(r_rdata),  int'(erd));
    endtask

    initial begin
        drive_l(OI, '0, '0, 1'b1);
        drive_r(OI, '0, '0, 1'b1);
        repeat (3) @(negedge clk);
        // R10: state held in reset
        check_all("R10", 1, 1, 0, 8'h00, 0, 8'h00);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [63:0] v;
            v = VEC[i];
            drive_l(v[63:62], v[61:51], v[50:43], v[42]);
            drive_r(v[41:40], v[39:29], v[28:21], v[20]);
            @(negedge clk);
            check_all(vreq(i), v[19], v[18], v[17], v[16:9], v[8], v[7:0]);
        end

        // R10: reset while the right interrupt is active and a read is requested
        rst = 1'b1;
        drive_l(OR, 11'h040, '0, 1'b1);
        drive_r(OI, '0, '0, 1'b1);
        @(negedge clk);
        check_all("R10", 1, 1, 0, 8'h00, 0, 8'h00);
        rst = 1'b0;

        // R10: memory survives reset
        drive_l(OR, 11'h040, '0, 1'b1);
        @(negedge clk);
        check_all("R10", 1, 1, 1, 8'hAA, 0, 8'h00);

        // R2: disabled port with read select and output enable low
        l_cen_n = 1'b1; l_rw = 1'b1; l_oe_n = 1'b0; l_addr = 11'h040;
        @(negedge clk);
        check_all("R2", 1, 1, 0, 8'h00, 0, 8'h00);

        // R4: inhibited right write to the left mailbox raises nothing, keeps data
        drive_l(OI, '0, '0, 1'b1);
        drive_r(OW, 11'h7FE, 8'h44, 1'b0);
        @(negedge clk);
        check_all("R4", 1, 1, 0, 8'h00, 0, 8'h00);
        drive_r(OI, '0, '0, 1'b1);
        drive_l(OR, 11'h7FE, '0, 1'b1);
        @(negedge clk);
        check_all("R4", 1, 1, 1, 8'hE1, 0, 8'h00);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (2000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule